// File: doc/BRIEF.md
# Dual-Clock FIFO Reset Sequencer

This block produces the reset sequence for a dual-clock FIFO and for the control logic on its write and read sides. It takes a raw active-low system reset, a write clock and a read clock. It drives an active-high reset into the FIFO's asynchronous reset port. After a counted hold-off it releases a second, extended reset for the surrounding read and write controllers. That extended reset enters each clock domain through its own multi-stage synchroniser. Each domain then raises a registered "ready" flag, which user logic ANDs into its FIFO enables.

The FIFO reset stays asserted until the read clock has been seen running and a write-clock hold count has elapsed. The extended reset is released a fixed number of write-clock cycles after the FIFO reset is released. Elaboration checks that both counts cover the required time in units of the slower clock. That time is three slow cycles for the pulse. For the quiet period it is 30 slow cycles, or 60 when safety mode is set. Asserting the system reset at any point restarts the sequence from the beginning.

Top module: `fifo_rst_seq`

## Requirements
- R1: While `sysRstN` is low, `fifoRst`, `extRst`, `wrCtlRst` and `rdCtlRst` are 1 and `wrReady`, `rdReady` are 0. `fifoRst` goes to 1 within the same time step that `sysRstN` falls, without waiting for a clock edge.
- R2: After `sysRstN` rises, `fifoRst` stays 1 for at least `HOLD_CYC` write-clock periods. That time is also at least 3 periods of the slower clock.
- R3: `fifoRst` is not released while the read clock has not produced a rising edge since the system reset.
- R4: `extRst` falls exactly `EXT_CYC` write-clock periods after `fifoRst` falls, and it is 1 whenever `fifoRst` is 1.
- R5: `wrCtlRst` falls on the 3rd write-clock rising edge after `extRst` falls, and `wrReady` rises one write-clock edge later. `rdCtlRst` falls on the 3rd read-clock rising edge after `extRst` falls, and `rdReady` rises one read-clock edge later.
- R6: `wrReady` and `rdReady` are never 1 while `fifoRst` or `extRst` is 1.
- R7: Both ready flags rise at least 30 slow-clock periods after `fifoRst` falls when `SAFETY_MODE`=0, and at least 60 when `SAFETY_MODE`=1.
- R8: Pulling `sysRstN` low in the middle of the sequence returns every output to its R1 state. After the release the whole sequence runs again with the same intervals.
- R9: Elaboration stops with an error if `HOLD_CYC` write periods are less than 3 slow periods. It also stops if `EXT_CYC` write periods are less than the required quiet time in slow periods.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| sysRstN | input | 1 | Raw system reset, active low, asynchronous |
| wrClk | input | 1 | FIFO write clock |
| rdClk | input | 1 | FIFO read clock |
| fifoRst | output | 1 | Active-high reset for the FIFO's asynchronous reset port (write-clock registered) |
| extRst | output | 1 | Extended reset, active high, write-clock registered |
| wrCtlRst | output | 1 | Extended reset synchronised to the write clock |
| rdCtlRst | output | 1 | Extended reset synchronised to the read clock |
| wrReady | output | 1 | Write side may access the FIFO |
| rdReady | output | 1 | Read side may access the FIFO |

## Verification
The hardest case to reach from the ports is a held FIFO reset caused by a dead read clock. The bench gates the read clock off and releases the system reset. It runs hundreds of write cycles with the FIFO reset still high, then restarts the read clock and watches the sequence complete. A second hard case is a reset arriving after the FIFO reset has fallen but before the extended reset has. The bench polls for the FIFO-reset fall and then pulls the system reset mid-countdown. Two instances run in parallel, one with safety mode off and one with it on. The read-clock period is unrelated to the write period, so each quiet interval is measured against the slow clock.

// File: rtl/fifo_rst_pkg.sv
package fifo_rst_pkg;
  typedef struct packed {
    logic relFifo;
    logic relExt;
  } seqStrobe_t;

  typedef enum logic [1:0] {
    SEQ_HOLD = 2'd0,
    SEQ_EXT  = 2'd1,
    SEQ_DONE = 2'd2
  } seqState_t;
endpackage

// File: rtl/rst_sync_chain.sv
module rst_sync_chain #(
  parameter int STAGES = 3
) (
  input  logic clk,
  input  logic rstIn,
  output logic rstOut
);
  logic [STAGES-1:0] pipe;

  always_ff @(posedge clk or posedge rstIn) begin
    if (rstIn) pipe <= '1;
    else       pipe <= {pipe[STAGES-2:0], 1'b0};
  end

  assign rstOut = pipe[STAGES-1];
endmodule

// File: rtl/rst_seq_ctrl.sv
module rst_seq_ctrl
  import fifo_rst_pkg::*;
#(
  parameter int HOLD_CYC = 8,
  parameter int EXT_CYC  = 50
) (
  input  logic       wrClk,
  input  logic       wrRstN,
  input  logic       rdAlive,
  output seqStrobe_t strb
);
  localparam int CNT_MAX = (HOLD_CYC > EXT_CYC) ? HOLD_CYC : EXT_CYC;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);

  seqState_t        state;
  logic [CNT_W-1:0] cnt;
  logic             holdEnd;
  logic             extEnd;

  assign holdEnd = (cnt == CNT_W'(HOLD_CYC - 1));
  assign extEnd  = (cnt == CNT_W'(EXT_CYC - 1));

  always_ff @(posedge wrClk or negedge wrRstN) begin
    if (!wrRstN) begin
      state <= SEQ_HOLD;
      cnt   <= '0;
    end else begin
      case (state)
        SEQ_HOLD: if (rdAlive) begin
          if (holdEnd) begin
            state <= SEQ_EXT;
            cnt   <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        SEQ_EXT: begin
          if (extEnd) begin
            state <= SEQ_DONE;
            cnt   <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: cnt <= '0;
      endcase
    end
  end

  always_comb begin
    strb.relFifo = (state == SEQ_HOLD) && rdAlive && holdEnd;
    strb.relExt  = (state == SEQ_EXT) && extEnd;
  end

  // R2
  cnt_bound_chk: assert property (@(posedge wrClk) disable iff (!wrRstN)
    cnt < CNT_W'(CNT_MAX));

  // R4
  single_release_chk: assert property (@(posedge wrClk) disable iff (!wrRstN)
    strb.relExt |=> !strb.relExt && !strb.relFifo);
endmodule

// File: rtl/rst_seq_path.sv
module rst_seq_path
  import fifo_rst_pkg::*;
#(
  parameter int SYNC_STAGES = 3
) (
  input  logic       wrClk,
  input  logic       rdClk,
  input  logic       sysRstN,
  input  seqStrobe_t strb,
  output logic       wrRstN,
  output logic       rdAliveW,
  output logic       fifoRst,
  output logic       extRst,
  output logic       wrCtlRst,
  output logic       rdCtlRst,
  output logic       wrReady,
  output logic       rdReady
);
  localparam int N_DOM = 2;

  logic sysRstHi;
  logic wrSysRst;
  logic rdAliveR;
  logic [1:0] aliveSync;
  logic [N_DOM-1:0] domClk;
  logic [N_DOM-1:0] domRst;
  logic [N_DOM-1:0] domRdy;

  assign sysRstHi = !sysRstN;

  rst_sync_chain #(.STAGES(2)) uSysSync (
    .clk(wrClk), .rstIn(sysRstHi), .rstOut(wrSysRst)
  );
  assign wrRstN = !wrSysRst;

  always_ff @(posedge rdClk or negedge sysRstN) begin
    if (!sysRstN) rdAliveR <= 1'b0;
    else          rdAliveR <= 1'b1;
  end

  always_ff @(posedge wrClk or negedge wrRstN) begin
    if (!wrRstN) aliveSync <= '0;
    else         aliveSync <= {aliveSync[0], rdAliveR};
  end
  assign rdAliveW = aliveSync[1];

  always_ff @(posedge wrClk or negedge wrRstN) begin
    if (!wrRstN) begin
      fifoRst <= 1'b1;
      extRst  <= 1'b1;
    end else begin
      if (strb.relFifo) fifoRst <= 1'b0;
      if (strb.relExt)  extRst  <= 1'b0;
    end
  end

  assign domClk = {rdClk, wrClk};

  for (genvar d = 0; d < N_DOM; d++) begin : g_dom
    rst_sync_chain #(.STAGES(SYNC_STAGES)) uExtSync (
      .clk(domClk[d]), .rstIn(extRst), .rstOut(domRst[d])
    );
    always_ff @(posedge domClk[d] or posedge domRst[d]) begin
      if (domRst[d]) domRdy[d] <= 1'b0;
      else           domRdy[d] <= 1'b1;
    end
  end

  assign wrCtlRst = domRst[0];
  assign rdCtlRst = domRst[1];
  assign wrReady  = domRdy[0];
  assign rdReady  = domRdy[1];

  // R4
  ext_covers_fifo_chk: assert property (@(posedge wrClk) disable iff (!wrRstN)
    fifoRst |-> extRst);

  // R3
  alive_before_release_chk: assert property (@(posedge wrClk) disable iff (!wrRstN)
    $fell(fifoRst) |-> rdAliveW);

  // R4
  ext_after_fifo_chk: assert property (@(posedge wrClk) disable iff (!wrRstN)
    $fell(extRst) |-> !fifoRst && $past(!fifoRst));

  // R6
  wr_ready_gated_chk: assert property (@(posedge wrClk) disable iff (!wrRstN)
    wrReady |-> !extRst && !fifoRst);
endmodule

// File: rtl/fifo_rst_seq.sv
module fifo_rst_seq
  import fifo_rst_pkg::*;
#(
  parameter int HOLD_CYC     = 8,
  parameter int EXT_CYC      = 50,
  parameter int WR_PERIOD_PS = 8000,
  parameter int RD_PERIOD_PS = 13000,
  parameter bit SAFETY_MODE  = 1'b0,
  parameter int SYNC_STAGES  = 3
) (
  input  logic sysRstN,
  input  logic wrClk,
  input  logic rdClk,
  output logic fifoRst,
  output logic extRst,
  output logic wrCtlRst,
  output logic rdCtlRst,
  output logic wrReady,
  output logic rdReady
);
  localparam longint SLOW_PS   = (WR_PERIOD_PS > RD_PERIOD_PS) ? WR_PERIOD_PS : RD_PERIOD_PS;
  localparam longint QUIET_CYC = SAFETY_MODE ? 60 : 30;
  localparam longint PULSE_CYC = 3;

  // R9
  if (longint'(HOLD_CYC) * WR_PERIOD_PS < PULSE_CYC * SLOW_PS) begin : g_badHold
    $fatal(1, "hold count too short for minimum FIFO reset pulse");
  end
  // R9
  if (longint'(EXT_CYC) * WR_PERIOD_PS < QUIET_CYC * SLOW_PS) begin : g_badExt
    $fatal(1, "extended hold-off too short for post-release quiet time");
  end

  seqStrobe_t strb;
  logic       wrRstN;
  logic       rdAliveW;

  rst_seq_ctrl #(.HOLD_CYC(HOLD_CYC), .EXT_CYC(EXT_CYC)) uCtrl (
    .wrClk(wrClk), .wrRstN(wrRstN), .rdAlive(rdAliveW), .strb(strb)
  );

  rst_seq_path #(.SYNC_STAGES(SYNC_STAGES)) uPath (
    .wrClk(wrClk), .rdClk(rdClk), .sysRstN(sysRstN), .strb(strb),
    .wrRstN(wrRstN), .rdAliveW(rdAliveW),
    .fifoRst(fifoRst), .extRst(extRst),
    .wrCtlRst(wrCtlRst), .rdCtlRst(rdCtlRst),
    .wrReady(wrReady), .rdReady(rdReady)
  );
endmodule

// File: tb/tb_fifo_rst_seq.sv
`timescale 1ns/1ps
module tb_fifo_rst_seq;
  localparam real WR_NS = 8.0;
  localparam real RD_NS = 13.0;
  localparam int  HOLD0 = 8, EXT0 = 50, HOLD1 = 8, EXT1 = 100;

  logic sysRstN = 1'b0, wrClk = 1'b0, rdClk = 1'b0;
  bit   rdRun = 1'b1;
  logic fr0, er0, wcr0, rcr0, wy0, ry0;
  logic fr1, er1, wcr1, rcr1, wy1, ry1;

  int vecCnt = 0, errCnt = 0, viol0 = 0, viol1 = 0;
  int q0[$], q1[$];
  real tRel, tF0, tE0, tWc0, tWy0, tRy0, tF1, tE1, tWc1, tWy1, tRy1;

  always #4 wrClk = ~wrClk;
  always begin #6.5; if (rdRun) rdClk = ~rdClk; end

  fifo_rst_seq #(.HOLD_CYC(HOLD0), .EXT_CYC(EXT0), .WR_PERIOD_PS(8000),
    .RD_PERIOD_PS(13000), .SAFETY_MODE(1'b0)) dut (
    .sysRstN(sysRstN), .wrClk(wrClk), .rdClk(rdClk), .fifoRst(fr0), .extRst(er0),
    .wrCtlRst(wcr0), .rdCtlRst(rcr0), .wrReady(wy0), .rdReady(ry0));

  fifo_rst_seq #(.HOLD_CYC(HOLD1), .EXT_CYC(EXT1), .WR_PERIOD_PS(8000),
    .RD_PERIOD_PS(13000), .SAFETY_MODE(1'b1)) dutSafe (
    .sysRstN(sysRstN), .wrClk(wrClk), .rdClk(rdClk), .fifoRst(fr1), .extRst(er1),
    .wrCtlRst(wcr1), .rdCtlRst(rcr1), .wrReady(wy1), .rdReady(ry1));

  task automatic chk(input bit ok, input string req, input string what,
                     input real act, input real exp);
    vecCnt++;
    if (!ok) begin
      errCnt++;
      $display("FAIL %s %s: actual %0.3f expected %0.3f", req, what, act, exp);
    end
  endtask

  // monitor: scoreboard of release events (1 = FIFO reset, 2 = extended reset)
  always @(negedge fr0) begin
    int got;
    tF0 = $realtime;
    got = (q0.size() > 0) ? q0.pop_front() : 0;
    chk(got == 1, "R4", "order dut fifo release", got, 1);
  end
  always @(negedge er0) begin
    int got;
    tE0 = $realtime;
    got = (q0.size() > 0) ? q0.pop_front() : 0;
    chk(got == 2, "R4", "order dut ext release", got, 2);
  end
  always @(negedge fr1) begin
    int got;
    tF1 = $realtime;
    got = (q1.size() > 0) ? q1.pop_front() : 0;
    chk(got == 1, "R4", "order safe fifo release", got, 1);
  end
  always @(negedge er1) begin
    int got;
    tE1 = $realtime;
    got = (q1.size() > 0) ? q1.pop_front() : 0;
    chk(got == 2, "R4", "order safe ext release", got, 2);
  end
  always @(negedge wcr0) tWc0 = $realtime;
  always @(posedge wy0)  tWy0 = $realtime;
  always @(posedge ry0)  tRy0 = $realtime;
  always @(negedge wcr1) tWc1 = $realtime;
  always @(posedge wy1)  tWy1 = $realtime;
  always @(posedge ry1)  tRy1 = $realtime;

  // R6 monitor, sampled away from the clock edges
  always @(negedge wrClk) begin
    if ((wy0 === 1'b1 || ry0 === 1'b1) && (fr0 !== 1'b0 || er0 !== 1'b0)) viol0++;
    if ((wy1 === 1'b1 || ry1 === 1'b1) && (fr1 !== 1'b0 || er1 !== 1'b0)) viol1++;
  end

  task automatic chkResetState(input string req);
    chk(fr0 === 1'b1 && fr1 === 1'b1, req, "fifoRst high", fr0, 1);
    chk(er0 === 1'b1 && er1 === 1'b1, req, "extRst high", er0, 1);
    chk(wcr0 === 1'b1 && rcr0 === 1'b1 && wcr1 === 1'b1 && rcr1 === 1'b1,
        req, "ctl resets high", wcr0, 1);
    chk(wy0 === 1'b0 && ry0 === 1'b0 && wy1 === 1'b0 && ry1 === 1'b0,
        req, "ready low", wy0, 0);
  endtask

  task automatic armScoreboard();
    q0.delete(); q1.delete();
    q0.push_back(1); q0.push_back(2);
    q1.push_back(1); q1.push_back(2);
  endtask

  task automatic waitDone();
    for (int i = 0; i < 4000; i++) begin
      @(negedge wrClk);
      if (wy0 && ry0 && wy1 && ry1) break;
    end
    #30;
  endtask

  task automatic checkTiming(input string tag);
    real d;
    chk(wy0 && ry0 && wy1 && ry1, "R5", {tag, " all ready"}, wy0 & ry0 & wy1 & ry1, 1);
    // R2: pulse length
    d = tF0 - tRel;
    chk(d >= HOLD0 * WR_NS - 0.01 && d >= 3 * RD_NS, "R2", {tag, " dut pulse"}, d, HOLD0 * WR_NS);
    d = tF1 - tRel;
    chk(d >= HOLD1 * WR_NS - 0.01 && d >= 3 * RD_NS, "R2", {tag, " safe pulse"}, d, HOLD1 * WR_NS);
    // R4: exact extended hold-off
    d = tE0 - tF0;
    chk(d > EXT0 * WR_NS - 0.01 && d < EXT0 * WR_NS + 0.01, "R4", {tag, " dut ext gap"}, d, EXT0 * WR_NS);
    d = tE1 - tF1;
    chk(d > EXT1 * WR_NS - 0.01 && d < EXT1 * WR_NS + 0.01, "R4", {tag, " safe ext gap"}, d, EXT1 * WR_NS);
    // R5: synchroniser latency
    d = tWc0 - tE0;
    chk(d > 3 * WR_NS - 0.01 && d < 3 * WR_NS + 0.01, "R5", {tag, " dut wr ctl"}, d, 3 * WR_NS);
    d = tWy0 - tE0;
    chk(d > 4 * WR_NS - 0.01 && d < 4 * WR_NS + 0.01, "R5", {tag, " dut wr ready"}, d, 4 * WR_NS);
    d = tWy1 - tE1;
    chk(d > 4 * WR_NS - 0.01 && d < 4 * WR_NS + 0.01, "R5", {tag, " safe wr ready"}, d, 4 * WR_NS);
    d = tRy0 - tE0;
    chk(d > 3 * RD_NS && d <= 4 * RD_NS + 0.01, "R5", {tag, " dut rd ready"}, d, 4 * RD_NS);
    d = tRy1 - tE1;
    chk(d > 3 * RD_NS && d <= 4 * RD_NS + 0.01, "R5", {tag, " safe rd ready"}, d, 4 * RD_NS);
    // R7: quiet period
    d = (tWy0 < tRy0 ? tWy0 : tRy0) - tF0;
    chk(d >= 30 * RD_NS, "R7", {tag, " dut quiet"}, d, 30 * RD_NS);
    d = (tWy1 < tRy1 ? tWy1 : tRy1) - tF1;
    chk(d >= 60 * RD_NS, "R7", {tag, " safe quiet"}, d, 60 * RD_NS);
  endtask

  initial begin
    #20;
    chkResetState("R1");

    // R3: read clock stopped, FIFO reset must hold
    armScoreboard();
    rdRun = 1'b0;
    @(negedge wrClk); sysRstN = 1'b1;
    repeat (300) @(negedge wrClk);
    chk(fr0 === 1'b1 && fr1 === 1'b1, "R3", "fifoRst held with dead read clock", fr0, 1);
    rdRun = 1'b1;
    waitDone();
    chk(fr0 === 1'b0 && er0 === 1'b0, "R3", "released once read clock runs", fr0, 0);

    // R1: asynchronous assertion
    sysRstN = 1'b0;
    #1;
    chk(fr0 === 1'b1 && fr1 === 1'b1, "R1", "fifoRst asserts asynchronously", fr0, 1);
    #40;
    chkResetState("R1");

    // full sequence with both clocks running
    armScoreboard();
    @(negedge wrClk); sysRstN = 1'b1; tRel = $realtime;
    waitDone();
    checkTiming("run");

    // R8: restart during the extended hold-off
    sysRstN = 1'b0; #40;
    armScoreboard();
    @(negedge wrClk); sysRstN = 1'b1;
    for (int i = 0; i < 500; i++) begin
      @(negedge wrClk);
      if (fr0 === 1'b0 && fr1 === 1'b0) break;
    end
    repeat (10) @(negedge wrClk);
    chk(er0 === 1'b1 && er1 === 1'b1, "R8", "mid-sequence ext still high", er0, 1);
    sysRstN = 1'b0;
    #1;
    chk(fr0 === 1'b1 && fr1 === 1'b1, "R8", "restart reasserts fifoRst", fr0, 1);
    #40;
    chkResetState("R8");
    armScoreboard();
    @(negedge wrClk); sysRstN = 1'b1; tRel = $realtime;
    waitDone();
    checkTiming("restart");

    chk(viol0 == 0 && viol1 == 0, "R6", "ready while a reset high", viol0 + viol1, 0);

    $display("== %0d vectors applied, %0d miscompares ==", vecCnt, errCnt);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge wrClk);
    errCnt++;
    vecCnt++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vecCnt, errCnt);
    $finish;
  end
endmodule